// File: doc/BRIEF.md
# Predicated Vector Element Stepper

This block walks the element loop of a predicated vector instruction. It keeps two step counters, one for source elements and one for destination elements. It also decides which element pair goes to execution next. Before each request, either counter moves past elements whose predicate bit is clear, and the two counters move independently of each other. When zeroing is enabled for a side, that side does not skip: the element is executed and a zero-result flag is raised for it. Neither counter ever goes past the vector length.

Instruction fetch, decode and execution sit outside the block. A start pulse hands over the vector length, both masks, both zeroing flags and a flag telling whether any operand is a vector. The configuration is captured in the idle state. Elements are offered to execution through a valid/ready handshake, and execution reports completion with a pulse. That pulse may flag that the program counter or step state was written elsewhere; in that case the block returns to idle and leaves both steps untouched, so that a later start resumes where the loop stopped. Every step change raises a one-cycle re-decode pulse, and every finished instruction raises a one-cycle done pulse.

Top module: `vec_step_seq`

## Requirements
- R1: After reset both steps are 0, and exec_valid_o, redecode_o, insn_done_o and both zero flags are low.
- R2: A start with a vector length of 0 raises insn_done_o for exactly one cycle, in the cycle after the start. No element is requested, and both steps read 0.
- R3: When source zeroing is off, source mask bit i (bit i = element i) is 0 at i = srcstep, and srcstep < VL, srcstep increments by one before execution is requested.
- R4: The destination step follows the R3 rule independently, using the destination mask and the destination zeroing flag.
- R5: Every step change other than the final clear raises redecode_o in the cycle the new value appears. exec_valid_o stays low in the following cycle, because the skip rule is re-evaluated before any request.
- R6: Execution is only requested with both steps below VL. If skipping drives either step to VL, the instruction finishes (R9) without executing that element.
- R7: When zeroing is on for a side, masked-out elements on that side are not skipped. They are executed with zero_src_o / zero_dst_o high during the request.
- R8: exec_valid_o, once raised, stays high with both steps stable until exec_ready_i is seen. The steps move only after a later elem_done_i pulse.
- R9: On elem_done_i for an element where srcstep+1 = VL or dststep+1 = VL, both steps return to 0 and insn_done_o pulses for one cycle.
- R10: When vec_i was 0 at start (no vector operand), the first completed element ends the instruction as in R9.
- R11: An elem_done_i with redirect_i high returns the block to idle, with both steps unchanged and no insn_done_o. A new start then continues from those steps.
- R12: Any other elem_done_i increments both steps by one and raises redecode_o (R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a new instruction, accepted when idle |
| vl_i | input | STEP_W | Vector length, 0 to MASK_W |
| src_mask_i | input | MASK_W | Source predicate, bit i for element i |
| dst_mask_i | input | MASK_W | Destination predicate, bit i for element i |
| src_zero_i | input | 1 | Source zeroing enable |
| dst_zero_i | input | 1 | Destination zeroing enable |
| vec_i | input | 1 | At least one operand is a vector |
| exec_valid_o | output | 1 | Element execution request |
| exec_ready_i | input | 1 | Execution accepts the request |
| elem_done_i | input | 1 | Element execution finished |
| redirect_i | input | 1 | With elem_done_i: PC or step state written during execution |
| srcstep_o | output | STEP_W | Current source step |
| dststep_o | output | STEP_W | Current destination step |
| zero_src_o | output | 1 | Requested source element is masked out under zeroing |
| zero_dst_o | output | 1 | Requested destination element is masked out under zeroing |
| redecode_o | output | 1 | One-cycle pulse: a step changed, re-decode needed |
| insn_done_o | output | 1 | One-cycle pulse: instruction finished |

## Verification
Several properties are checked in every cycle: steps stay below VL while a request is up, the request and steps hold through a stalled handshake, a step never changes without a redecode or done pulse, redecode is always followed by a cycle without a request, done always shows zero steps, and zero flags appear only with a request. Whether the right elements are chosen can only be shown by the bench scenarios. That covers the exact sequence of executed pairs under independent source and destination masks, the number of re-decode pulses, finishing when a skip reaches VL, scalar operation and resuming after a redirect. The bench sweeps masks, lengths and zeroing combinations on an 8-element configuration and compares the results against an arithmetic walk of the rules.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CHECK  = 3'd1,
    ST_DECODE = 3'd2,
    ST_EXEC   = 3'd3,
    ST_WAIT   = 3'd4
  } vstep_state_e;

  localparam int unsigned NUM_LANES = 2;  // lane 0 = source, lane 1 = destination

endpackage

// File: rtl/vstep_lane.sv
module vstep_lane #(
  parameter  int unsigned MASK_W = 64,
  localparam int unsigned STEP_W = $clog2(MASK_W + 1),
  localparam int unsigned IDX_W  = $clog2(MASK_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              zero_en_i,
  input  logic [STEP_W-1:0] vl_i,
  input  logic              skip_take_i,
  input  logic              inc_i,
  input  logic              clr_i,
  output logic [STEP_W-1:0] step_o,
  output logic              skip_req_o,
  output logic              at_end_o,
  output logic              last_o,
  output logic              zero_elem_o
);

  logic [STEP_W-1:0] step_q, step_d, step_plus1;
  logic              step_en;
  logic              pred_bit;
  logic              in_range;

  // increment prepared ahead of any decision
  assign step_plus1 = step_q + STEP_W'(1);
  assign in_range   = (step_q < vl_i);

  always_comb begin
    pred_bit = 1'b1;
    if (step_q < STEP_W'(MASK_W)) begin
      pred_bit = mask_i[step_q[IDX_W-1:0]];
    end
  end

  assign skip_req_o  = ~zero_en_i & ~pred_bit & in_range;
  assign at_end_o    = ~in_range;
  assign last_o      = (step_plus1 == vl_i);
  assign zero_elem_o = zero_en_i & ~pred_bit;

  always_comb begin
    step_en = 1'b0;
    step_d  = step_q;
    if (clr_i) begin
      step_en = 1'b1;
      step_d  = '0;
    end else if (inc_i || (skip_take_i && skip_req_o)) begin
      step_en = 1'b1;
      step_d  = step_plus1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  assign step_o = step_q;

endmodule

// File: rtl/vstep_ctrl.sv
module vstep_ctrl
  import vstep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic vl_zero_i,
  input  logic vec_i,
  input  logic skip_any_i,
  input  logic end_any_i,
  input  logic last_any_i,
  input  logic exec_ready_i,
  input  logic elem_done_i,
  input  logic redirect_i,
  output logic cfg_load_o,
  output logic skip_take_o,
  output logic inc_o,
  output logic clr_o,
  output logic exec_valid_o,
  output logic redecode_o,
  output logic done_o
);

  vstep_state_e state_q, state_d;
  logic         done_q, done_d;
  logic         redec_q, redec_d;

  always_comb begin
    state_d      = state_q;
    cfg_load_o   = 1'b0;
    skip_take_o  = 1'b0;
    inc_o        = 1'b0;
    clr_o        = 1'b0;
    exec_valid_o = 1'b0;
    done_d       = 1'b0;
    redec_d      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cfg_load_o = 1'b1;
          if (vl_zero_i) begin
            clr_o  = 1'b1;
            done_d = 1'b1;
          end else begin
            state_d = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (skip_any_i) begin
          skip_take_o = 1'b1;
          redec_d     = 1'b1;
          state_d     = ST_DECODE;
        end else if (end_any_i) begin
          clr_o   = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_EXEC;
        end
      end
      ST_DECODE: begin
        state_d = ST_CHECK;
      end
      ST_EXEC: begin
        exec_valid_o = 1'b1;
        if (exec_ready_i) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (elem_done_i) begin
          if (redirect_i) begin
            state_d = ST_IDLE;
          end else if (!vec_i || last_any_i) begin
            clr_o   = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            inc_o   = 1'b1;
            redec_d = 1'b1;
            state_d = ST_DECODE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      redec_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      redec_q <= redec_d;
    end
  end

  assign redecode_o = redec_q;
  assign done_o     = done_q;

endmodule

// File: rtl/vec_step_seq.sv
module vec_step_seq
  import vstep_pkg::*;
#(
  parameter  int unsigned MASK_W = 64,
  localparam int unsigned STEP_W = $clog2(MASK_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STEP_W-1:0] vl_i,
  input  logic [MASK_W-1:0] src_mask_i,
  input  logic [MASK_W-1:0] dst_mask_i,
  input  logic              src_zero_i,
  input  logic              dst_zero_i,
  input  logic              vec_i,
  output logic              exec_valid_o,
  input  logic              exec_ready_i,
  input  logic              elem_done_i,
  input  logic              redirect_i,
  output logic [STEP_W-1:0] srcstep_o,
  output logic [STEP_W-1:0] dststep_o,
  output logic              zero_src_o,
  output logic              zero_dst_o,
  output logic              redecode_o,
  output logic              insn_done_o
);

  // captured instruction configuration
  logic [STEP_W-1:0] vl_q;
  logic [MASK_W-1:0] mask_q [NUM_LANES];
  logic [MASK_W-1:0] mask_in [NUM_LANES];
  logic              zero_q [NUM_LANES];
  logic              zero_in [NUM_LANES];
  logic              vec_q;
  logic              cfg_load;

  assign mask_in[0] = src_mask_i;
  assign mask_in[1] = dst_mask_i;
  assign zero_in[0] = src_zero_i;
  assign zero_in[1] = dst_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q  <= '0;
      vec_q <= 1'b0;
    end else if (cfg_load) begin
      vl_q  <= vl_i;
      vec_q <= vec_i;
    end
  end

  // per-lane outputs
  logic [STEP_W-1:0] step   [NUM_LANES];
  logic [NUM_LANES-1:0] skip_req, at_end, last, zero_elem;
  logic skip_take, inc, clr;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[g] <= '0;
        zero_q[g] <= 1'b0;
      end else if (cfg_load) begin
        mask_q[g] <= mask_in[g];
        zero_q[g] <= zero_in[g];
      end
    end

    vstep_lane #(.MASK_W(MASK_W)) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mask_i      (mask_q[g]),
      .zero_en_i   (zero_q[g]),
      .vl_i        (vl_q),
      .skip_take_i (skip_take),
      .inc_i       (inc),
      .clr_i       (clr),
      .step_o      (step[g]),
      .skip_req_o  (skip_req[g]),
      .at_end_o    (at_end[g]),
      .last_o      (last[g]),
      .zero_elem_o (zero_elem[g])
    );
  end

  vstep_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .vl_zero_i    (vl_i == '0),
    .vec_i        (vec_q),
    .skip_any_i   (|skip_req),
    .end_any_i    (|at_end),
    .last_any_i   (|last),
    .exec_ready_i (exec_ready_i),
    .elem_done_i  (elem_done_i),
    .redirect_i   (redirect_i),
    .cfg_load_o   (cfg_load),
    .skip_take_o  (skip_take),
    .inc_o        (inc),
    .clr_o        (clr),
    .exec_valid_o (exec_valid_o),
    .redecode_o   (redecode_o),
    .done_o       (insn_done_o)
  );

  assign srcstep_o  = step[0];
  assign dststep_o  = step[1];
  assign zero_src_o = exec_valid_o & zero_elem[0];
  assign zero_dst_o = exec_valid_o & zero_elem[1];

endmodule

// File: rtl/vstep_chk.sv
module vstep_chk #(
  parameter int unsigned STEP_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STEP_W-1:0] vl,
  input logic [STEP_W-1:0] srcstep,
  input logic [STEP_W-1:0] dststep,
  input logic              exec_valid,
  input logic              exec_ready,
  input logic              redecode,
  input logic              done,
  input logic              zero_src,
  input logic              zero_dst
);

  // R6
  req_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid |-> (srcstep < vl) && (dststep < vl));

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid && !exec_ready |=> exec_valid && $stable(srcstep) && $stable(dststep));

  // R5
  redecode_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redecode |=> !exec_valid);

  // R5
  src_change_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(srcstep) |-> redecode || done);

  // R5
  dst_change_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dststep) |-> redecode || done);

  // R9
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> (srcstep == '0) && (dststep == '0) && !redecode);

  // R7
  zero_with_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_src || zero_dst) |-> exec_valid);

endmodule

bind vec_step_seq vstep_chk #(.STEP_W(STEP_W)) u_vstep_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vl         (vl_q),
  .srcstep    (srcstep_o),
  .dststep    (dststep_o),
  .exec_valid (exec_valid_o),
  .exec_ready (exec_ready_i),
  .redecode   (redecode_o),
  .done       (insn_done_o),
  .zero_src   (zero_src_o),
  .zero_dst   (zero_dst_o)
);

// File: tb/test_vec_step_seq.sv
module test_vec_step_seq;

  localparam int unsigned MW = 8;
  localparam int unsigned SW = $clog2(MW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [SW-1:0] vl_i = '0;
  logic [MW-1:0] src_mask_i = '0, dst_mask_i = '0;
  logic          src_zero_i = 1'b0, dst_zero_i = 1'b0, vec_i = 1'b0;
  logic          exec_ready_i = 1'b0, elem_done_i = 1'b0, redirect_i = 1'b0;
  logic          exec_valid_o, zero_src_o, zero_dst_o, redecode_o, insn_done_o;
  logic [SW-1:0] srcstep_o, dststep_o;

  int n_vec = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vec_step_seq #(.MASK_W(MW)) i_vec_step_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .vl_i(vl_i),
    .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i),
    .src_zero_i(src_zero_i), .dst_zero_i(dst_zero_i), .vec_i(vec_i),
    .exec_valid_o(exec_valid_o), .exec_ready_i(exec_ready_i),
    .elem_done_i(elem_done_i), .redirect_i(redirect_i),
    .srcstep_o(srcstep_o), .dststep_o(dststep_o),
    .zero_src_o(zero_src_o), .zero_dst_o(zero_dst_o),
    .redecode_o(redecode_o), .insn_done_o(insn_done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected walk, computed from the requirements
  int exp_s [64], exp_d [64], exp_zs [64], exp_zd [64];
  int exp_n, exp_red;

  task automatic model(input int vl, input logic [MW-1:0] sm, dm,
                       input logic zs, zd, vec, input int s0, d0);
    int s = s0, d = d0;
    bit stop = 0;
    exp_n = 0; exp_red = 0;
    if (vl == 0) return;
    for (int it = 0; it < 64 && !stop; it++) begin
      bit ks, kd;
      ks = !zs && (s < vl) && !sm[s];
      kd = !zd && (d < vl) && !dm[d];
      if (ks || kd) begin
        if (ks) s++;
        if (kd) d++;
        exp_red++;
      end else if (s >= vl || d >= vl) begin
        stop = 1;
      end else begin
        exp_s[exp_n]  = s;
        exp_d[exp_n]  = d;
        exp_zs[exp_n] = int'(zs && !sm[s]);
        exp_zd[exp_n] = int'(zd && !dm[d]);
        exp_n++;
        if (!vec || s + 1 == vl || d + 1 == vl) stop = 1;
        else begin s++; d++; exp_red++; end
      end
    end
  endtask

  task automatic run_insn(input int vl, input logic [MW-1:0] sm, dm,
                          input logic zs, zd, vec, input int s0, d0, input int redir_k);
    int  k = 0, red = 0;
    bit  got_done = 0, redirected = 0;
    model(vl, sm, dm, zs, zd, vec, s0, d0);
    vl_i = SW'(vl); src_mask_i = sm; dst_mask_i = dm;
    src_zero_i = zs; dst_zero_i = zd; vec_i = vec;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 400 && !got_done && !redirected; c++) begin
      if (redecode_o) red++;
      if (insn_done_o) begin
        got_done = 1;
        chk(srcstep_o == 0 && dststep_o == 0, "R9 steps cleared at done",
            int'(srcstep_o) * 100 + int'(dststep_o), 0);
      end else if (exec_valid_o) begin
        if (k < exp_n) begin
          chk(srcstep_o == SW'(exp_s[k]), "R3 R12 source step of element",
              int'(srcstep_o), exp_s[k]);
          chk(dststep_o == SW'(exp_d[k]), "R4 R12 destination step of element",
              int'(dststep_o), exp_d[k]);
          chk(int'(zero_src_o) == exp_zs[k] && int'(zero_dst_o) == exp_zd[k],
              "R7 zero flags", int'(zero_src_o) * 10 + int'(zero_dst_o),
              exp_zs[k] * 10 + exp_zd[k]);
        end else begin
          chk(0, "R6 request beyond expected elements", k, exp_n);
        end
        @(negedge clk);
        chk(exec_valid_o && srcstep_o == SW'(exp_s[k]) && dststep_o == SW'(exp_d[k]),
            "R8 request held while not ready", int'(exec_valid_o), 1);
        exec_ready_i = 1'b1;
        @(negedge clk);
        exec_ready_i = 1'b0;
        elem_done_i  = 1'b1;
        redirect_i   = (k == redir_k);
        @(negedge clk);
        elem_done_i = 1'b0;
        redirect_i  = 1'b0;
        if (k == redir_k) redirected = 1;
        k++;
      end else begin
        @(negedge clk);
      end
    end
    if (redirected) begin
      for (int c = 0; c < 3; c++) begin
        chk(!insn_done_o && !exec_valid_o && srcstep_o == SW'(exp_s[redir_k]) &&
            dststep_o == SW'(exp_d[redir_k]), "R11 idle with steps kept after redirect",
            int'(srcstep_o) * 100 + int'(dststep_o), exp_s[redir_k] * 100 + exp_d[redir_k]);
        @(negedge clk);
      end
    end else begin
      chk(got_done, (vl == 0) ? "R2 done for zero length" : "R9 done pulse seen",
          int'(got_done), 1);
      chk(k == exp_n, vec ? "R6 executed element count" : "R10 scalar element count",
          k, exp_n);
      chk(red == exp_red, "R5 redecode pulse count", red, exp_red);
      @(negedge clk);
      chk(!insn_done_o, "R2 R9 done is one cycle wide", int'(insn_done_o), 0);
    end
  endtask

  initial begin
    #(10 * 195000);
    chk(0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(srcstep_o == 0 && dststep_o == 0 && !exec_valid_o && !redecode_o && !insn_done_o &&
        !zero_src_o && !zero_dst_o, "R1 reset state", int'(srcstep_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(srcstep_o == 0 && !exec_valid_o && !insn_done_o, "R1 after release",
        int'(exec_valid_o), 0);

    // R2 zero length with various masks
    run_insn(0, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b1, 0, 0, -1);
    run_insn(0, 8'hFF, 8'h00, 1'b1, 1'b1, 1'b1, 0, 0, -1);

    // R3 R4 R6 R7 sweep across lengths, source masks and zeroing
    for (int vl = 0; vl <= MW; vl++) begin
      for (int m = 0; m < 256; m += 5) begin
        for (int z = 0; z < 4; z++) begin
          logic [MW-1:0] sm, dm;
          sm = MW'(m);
          dm = {sm[2:0], sm[7:3]} ^ 8'h5A;
          run_insn(vl, sm, dm, z[0], z[1], 1'b1, 0, 0, -1);
        end
      end
    end

    // R6 source mask empty: skipping reaches VL, nothing executes
    run_insn(5, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b1, 0, 0, -1);
    // R10 scalar operation
    run_insn(6, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 0, 0, -1);
    run_insn(6, 8'hF4, 8'h38, 1'b0, 1'b0, 1'b0, 0, 0, -1);
    // R11 redirect on second element, then resume from kept steps
    run_insn(6, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 0, 0, 1);
    run_insn(6, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 1, 1, -1);
    run_insn(7, 8'hB6, 8'hDD, 1'b0, 1'b0, 1'b1, 0, 0, 2);
    run_insn(7, 8'hB6, 8'hDD, 1'b0, 1'b0, 1'b1, exp_s[2], exp_d[2], -1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule